// File: doc/BRIEF.md
# Configurable Command/Address Registered Buffer

This block registers a memory command and address bus on the rising clock edge and presents the registered values to its outputs. Two static configuration inputs pick its shape. In the wide shape it is a 25-bit register with one output per bit. In the narrow shape it is a 14-bit register whose outputs each drive two copies, an A copy and a B copy. The narrow shape has two bit maps, and the map decides which bit positions carry clock enable and on-die termination.

A pair of active-low chip selects can freeze the ordinary data outputs to save switching power. The first chip select travels on the data bus at bit index 6. The second has its own input. When both are high at a clock edge, the ordinary data bits keep their previous value. The clock-enable, termination and chip-select bits keep updating. An active-low reset, sampled on the clock, clears the whole register and has priority over the gating.

Top module: `ssb_regbuf`

## Requirements
- R1: With `cfg_half` = 0, every bit of `q_a[24:0]` takes the `din` value captured at the previous rising edge when loading is enabled, and `q_b` is all zero.
- R2: With `cfg_half` = 1, only `q_a[13:0]` are registered. `q_b[13:0]` always equals `q_a[13:0]`. `q_a[24:14]` is zero, and `din[24:14]` has no effect on any output.
- R3: When `din[6]` or `cs_rank_n` is low at a rising edge, all active bits load their new input.
- R4: When `din[6]` and `cs_rank_n` are both high at a rising edge, every gated bit keeps its previous output value.
- R5: In the wide shape and in narrow map A (`cfg_half` = 1, `cfg_bsel` = 0), bit indices 0 (clock enable), 3 (termination) and 6 (chip select) load on every edge, whatever the gating does.
- R6: When `rst_n` is low at a rising edge, both output buses become zero at that edge. Reset overrides gating.
- R7: In narrow map B (`cfg_half` = 1, `cfg_bsel` = 1), bit indices 13 (clock enable), 10 (termination) and 6 (chip select) always load. Indices 0 and 3 are gated like ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| cfg_half | input | 1 | Static shape select: 0 = 25-bit wide, 1 = 14-bit dual copy |
| cfg_bsel | input | 1 | Static narrow map select: 0 = map A, 1 = map B |
| din | input | 25 | Command/address inputs. Index 6 is the first active-low chip select |
| cs_rank_n | input | 1 | Second active-low chip select |
| q_a | output | 25 | Primary registered outputs (A copy in narrow shape) |
| q_b | output | 14 | Secondary copy in narrow shape, zero in wide shape |

## Verification
The assertions check every cycle that reset clears both buses and that a gated data bit holds while both selects are high. They also check that it loads when either select is low, that the chip-select bit always follows its input, that the map-B clock-enable bit always loads, and that the upper bits stay zero in the narrow shape. Other behaviours can only be shown by the bench's scenarios. These are the full per-map set of ungated positions, the fact that inputs 24..14 are ignored in the narrow shape, and the move of clock enable and termination between maps. The bench compares whole output buses against a bench model across random traffic in all three configurations.

// File: rtl/ssb_pkg.sv
// Package for the configurable registered buffer.
// Holds the shape enum, the fixed positions of the ungated control bits,
// and a helper that builds the ungated-bit mask for a given shape.
// Assumes bus widths no larger than 32 bits for the mask helper.
package ssb_pkg;

    typedef enum logic [1:0] {
        SHAPE_WIDE     = 2'd0,
        SHAPE_NARROW_A = 2'd1,
        SHAPE_NARROW_B = 2'd2
    } shape_e;

    // Control bit positions that escape chip-select gating
    localparam int unsigned SEL_IDX      = 6;
    localparam int unsigned CKE_IDX_A    = 0;
    localparam int unsigned ODT_IDX_A    = 3;
    localparam int unsigned CKE_IDX_B    = 13;
    localparam int unsigned ODT_IDX_B    = 10;

    // Build the mask of bits that load on every edge for a shape
    function automatic logic [31:0] ungated_mask(input shape_e shape);
        logic [31:0] m;
        m = '0;
        m[SEL_IDX] = 1'b1;
        if (shape == SHAPE_NARROW_B) begin
            m[CKE_IDX_B] = 1'b1;
            m[ODT_IDX_B] = 1'b1;
        end else begin
            m[CKE_IDX_A] = 1'b1;
            m[ODT_IDX_A] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ssb_cfg_decode.sv
// Configuration decoder.
// Turns the two static shape pins into a shape code, the mask of bit
// positions that are in use, and the mask of bits exempt from gating.
// Assumes the configuration pins do not change while traffic runs.
module ssb_cfg_decode
    import ssb_pkg::*;
#(
    parameter int unsigned DATA_W   = 25,
    parameter int unsigned NARROW_W = 14
) (
    input  logic              cfg_half,
    input  logic              cfg_bsel,
    output logic [DATA_W-1:0] used_mask,
    output logic [DATA_W-1:0] free_mask
);

    shape_e      shape;
    logic [31:0] full_free;

    // Pick the shape from the two pins; map select only counts when narrow
    always_comb begin
        if (!cfg_half)      shape = SHAPE_WIDE;
        else if (!cfg_bsel) shape = SHAPE_NARROW_A;
        else                shape = SHAPE_NARROW_B;
    end

    // Mark which positions hold live data in the chosen shape
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            used_mask[i] = (shape == SHAPE_WIDE) || (i < NARROW_W);
        end
    end

    // Fetch the ungated positions and trim them to the bus width
    always_comb begin
        full_free = ungated_mask(shape);
        free_mask = full_free[DATA_W-1:0];
    end

endmodule

// File: rtl/ssb_gate_ctl.sv
// Chip-select gating control.
// Works out a per-bit load enable: a bit loads unless both active-low
// selects are high, and ungated control bits load regardless.
// Assumes the select inputs are already synchronous to the clock.
module ssb_gate_ctl #(
    parameter int unsigned DATA_W  = 25,
    parameter int unsigned SEL_POS = 6
) (
    input  logic [DATA_W-1:0] din,
    input  logic              cs_rank_n,
    input  logic [DATA_W-1:0] free_mask,
    output logic [DATA_W-1:0] load_en
);

    logic idle;

    // Both selects deasserted means the bus is idle and may freeze
    always_comb idle = din[SEL_POS] & cs_rank_n;

    // Per-bit enable: load when not idle or when the bit is exempt
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            load_en[i] = !idle || free_mask[i];
        end
    end

endmodule

// File: rtl/ssb_bit_slice.sv
// One registered bit of the buffer.
// Clears on reset, is forced to zero when the position is unused in the
// current shape, loads its input when enabled, and holds otherwise.
// Assumes a synchronous active-low reset.
module ssb_bit_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic used,
    input  logic load,
    input  logic d,
    output logic q
);

    // Storage flop with reset over unused-clear over load over hold
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (!used) q <= 1'b0;
        else if (load)  q <= d;
    end

endmodule

// File: rtl/ssb_regbuf.sv
// Configurable command/address registered buffer, top level.
// Registers up to DATA_W inputs with chip-select gating and presents them
// on a primary bus plus, in the narrow shape, an identical secondary copy.
// Assumes cfg_half and cfg_bsel are static and the reset is synchronous.
module ssb_regbuf
    import ssb_pkg::*;
#(
    parameter int unsigned DATA_W   = 25,
    parameter int unsigned NARROW_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_half,
    input  logic                cfg_bsel,
    input  logic [DATA_W-1:0]   din,
    input  logic                cs_rank_n,
    output logic [DATA_W-1:0]   q_a,
    output logic [NARROW_W-1:0] q_b
);

    localparam int unsigned SEL_POS = SEL_IDX;

    logic [DATA_W-1:0] used_mask;
    logic [DATA_W-1:0] free_mask;
    logic [DATA_W-1:0] load_en;
    logic [DATA_W-1:0] q_reg;

    ssb_cfg_decode #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_decode (
        .cfg_half  (cfg_half),
        .cfg_bsel  (cfg_bsel),
        .used_mask (used_mask),
        .free_mask (free_mask)
    );

    ssb_gate_ctl #(.DATA_W(DATA_W), .SEL_POS(SEL_POS)) u_gate (
        .din       (din),
        .cs_rank_n (cs_rank_n),
        .free_mask (free_mask),
        .load_en   (load_en)
    );

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        ssb_bit_slice u_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .used  (used_mask[i]),
            .load  (load_en[i]),
            .d     (din[i]),
            .q     (q_reg[i])
        );
    end

    // Primary bus carries the register directly
    always_comb q_a = q_reg;

    // Secondary copy mirrors the low bits in the narrow shape only
    always_comb q_b = cfg_half ? q_reg[NARROW_W-1:0] : '0;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (q_a == '0 && q_b == '0)); // R6

    AST_LOAD_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !(din[SEL_POS] && cs_rank_n) |=> (q_a[1] == $past(din[1]))); // R3

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (din[SEL_POS] && cs_rank_n) |=> (q_a[1] == $past(q_a[1]))); // R4

    AST_SELECT_BIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_a[SEL_POS] == $past(din[SEL_POS]))); // R5

    AST_MAP_B_CKE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_half && cfg_bsel) |=> (q_a[CKE_IDX_B] == $past(din[CKE_IDX_B]))); // R7

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_half |=> (q_a[DATA_W-1:NARROW_W] == '0)); // R2

endmodule

// File: tb/tb_ssb_regbuf.sv
module tb_ssb_regbuf;

    localparam int DATA_W   = 25;
    localparam int NARROW_W = 14;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                cfg_half;
    logic                cfg_bsel;
    logic [DATA_W-1:0]   din;
    logic                cs_rank_n;
    logic [DATA_W-1:0]   q_a;
    logic [NARROW_W-1:0] q_b;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] expv;
    bit done = 0;

    always #10 clk = ~clk;

    ssb_regbuf #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_bsel(cfg_bsel),
        .din(din), .cs_rank_n(cs_rank_n), .q_a(q_a), .q_b(q_b)
    );

    // Bench model of the next register value, built from the requirements
    function automatic logic [DATA_W-1:0] model_next(
        input logic [DATA_W-1:0] prev, input logic [DATA_W-1:0] d,
        input logic c, input logic r, input logic half, input logic bsel);
        logic [DATA_W-1:0] n;
        logic idle;
        logic byp;
        n = '0;
        if (!r) return n;
        idle = d[6] & c;
        for (int i = 0; i < DATA_W; i++) begin
            if (half && bsel) byp = (i == 13) || (i == 10) || (i == 6);
            else              byp = (i == 0) || (i == 3) || (i == 6);
            if (half && i >= NARROW_W) n[i] = 1'b0;
            else if (!idle || byp)     n[i] = d[i];
            else                       n[i] = prev[i];
        end
        return n;
    endfunction

    task automatic check(input string tag);
        logic [NARROW_W-1:0] eb;
        eb = cfg_half ? expv[NARROW_W-1:0] : '0;
        checks++;
        if (q_a !== expv || q_b !== eb) begin
            errors++;
            $display("FAIL %s: q_a=%h q_b=%h expected q_a=%h q_b=%h",
                     tag, q_a, q_b, expv, eb);
        end
    endtask

    // Drive one cycle at the falling edge, update the model, check next fall
    task automatic step(input logic [DATA_W-1:0] d, input logic c,
                        input logic r, input string tag);
        din = d; cs_rank_n = c; rst_n = r;
        @(posedge clk);
        expv = model_next(expv, d, c, r, cfg_half, cfg_bsel);
        @(negedge clk);
        check(tag);
    endtask

    task automatic random_run(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            logic [DATA_W-1:0] d;
            logic c;
            d = DATA_W'($urandom);
            c = ($urandom % 3) != 0;
            if (($urandom % 2) == 0) d[6] = 1'b1;
            step(d, c, 1'b1, tag);
        end
    endtask

    initial begin
        #(20 * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        cfg_half = 1'b0; cfg_bsel = 1'b0;
        din = '0; cs_rank_n = 1'b0; rst_n = 1'b0;
        expv = '0;
        @(negedge clk);
        step('0, 1'b0, 1'b0, "R6 reset state");

        // Wide shape, directed
        step('1, 1'b0, 1'b1, "R1 wide full load");
        step(25'h0AAAAA, 1'b0, 1'b1, "R3 load via rank select low");
        step(25'h155555 | 25'h40, 1'b0, 1'b1, "R3 load via bit6 select high, rank low");
        step(25'h000040, 1'b1, 1'b1, "R4 R5 idle holds data, controls follow");
        step(25'h1FFFFF, 1'b1, 1'b1, "R5 wide controls 0,3,6 load when idle");
        step(25'h1FFFFF, 1'b1, 1'b0, "R6 reset overrides gating");
        random_run(400, "R1 R3 R4 R5 wide random");

        // Narrow map A
        cfg_half = 1'b1; cfg_bsel = 1'b0;
        step('0, 1'b0, 1'b0, "R6 reset before map A");
        step(25'h1FFC000, 1'b0, 1'b1, "R2 upper inputs ignored");
        step(25'h1FFFFFF, 1'b0, 1'b1, "R2 narrow copy");
        step(25'h0000040, 1'b1, 1'b1, "R5 map A idle controls follow");
        random_run(400, "R2 R4 R5 map A random");

        // Narrow map B
        cfg_bsel = 1'b1;
        step('0, 1'b0, 1'b0, "R6 reset before map B");
        step(25'h0003FFF, 1'b0, 1'b1, "R2 map B load");
        step(25'h0000040, 1'b1, 1'b1, "R7 map B idle: 0,3 hold, 13,10 follow");
        step(25'h1FFFFFF, 1'b1, 1'b1, "R7 map B idle: 13,10 load ones");
        random_run(400, "R2 R4 R7 map B random");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule